// File: doc/BRIEF.md
# Radix-4 GF(2^m) Multiply Step

This block is one combinational step of a polynomial-basis multiplier over GF(2^m). It advances a partial product by two multiplier bits at once: the previous partial product is multiplied by alpha squared and reduced, and then the operand and the operand times alpha are added according to a pair of multiplier bits. A surrounding datapath feeds it the pairs of multiplier bits from the most significant end, one pair per step. After m/2 steps, starting from a zero partial product, the result is the field product.

All reduction and operand terms come from 4-to-1 selections rather than AND/XOR products. For every bit position, one selection is keyed by the pair formed from the field polynomial coefficient and the reduced alpha^(m+1) coefficient. A second selection is keyed by the pair formed from the operand bit and the bit of operand times alpha. A 3-input XOR merges the two selections with the shifted partial-product bit. The XOR of the two top partial-product bits and the XOR of the two multiplier bits are formed once per step and shared by every position. The field polynomial is an input port, so the block serves any field of width M. Producing the operand times alpha and the alpha^(m+1) coefficients, sequencing the steps and any pipelining are left to the surrounding logic.

Top module: `gfr4_step`

## Requirements
- R1: `t_next` equals `t_prev`·α² + `a_shift`·`b_hi` + `a_op`·`b_lo` reduced modulo P. Bit j of `poly` is the coefficient of x^j in P (the x^M term is implied). `a_shift` is `a_op`·α reduced. `poly_up` is α^(M+1) reduced, which equals `poly`·α reduced.
- R2: Bits 0 and 1 of `t_next` take no shifted partial-product term. With `b_hi`=`b_lo`=0 and the top two bits of `t_prev` zero, `t_next[1:0]` is 0.
- R3: The reduction term of bit j is selected by the pair (`poly[j]`, `poly_up[j]`). The pair (0,0) gives 0. The pair (1,0) gives `t_prev[M-2]`. The pair (0,1) gives `t_prev[M-1]`. The pair (1,1) gives their XOR.
- R4: The operand term of bit j is selected by the pair (`a_op[j]`, `a_shift[j]`). The pair (0,0) gives 0. The pair (1,0) gives `b_lo`. The pair (0,1) gives `b_hi`. The pair (1,1) gives `b_lo` XOR `b_hi`.
- R5: With `b_hi`=`b_lo`=0, `t_next` is `t_prev`·α² reduced, whatever the value of `a_op`.
- R6: With `t_prev[M-1:M-2]`=0, `t_next` is `t_prev` shifted up by two bits plus the operand terms, whatever the values of `poly` and `poly_up`.
- R7: The field polynomial is taken from the port. The same `t_prev`, `a_op` and multiplier bits give the correctly reduced result for each of several irreducible polynomials.
- R8: Starting from `t_prev`=0 and applying the bit pairs (b[M-1],b[M-2]), then (b[M-3],b[M-4]), and so on for M/2 steps gives A·B mod P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| t_prev | input | M | Previous partial product, bit j = coefficient of α^j |
| a_op | input | M | Operand A |
| a_shift | input | M | A·α reduced (precomputed outside) |
| poly | input | M | Field polynomial coefficients below x^M |
| poly_up | input | M | α^(M+1) reduced modulo the field polynomial |
| b_hi | input | 1 | Upper multiplier bit of the current pair |
| b_lo | input | 1 | Lower multiplier bit of the current pair |
| t_next | output | M | Next partial product |

## Verification
Random stimulus that stays inside consistent field values rarely makes the two selections at one bit position go through all four keys together with all four candidate values. The bench therefore also drives `poly_up` and `a_shift` directly, as free patterns that place every key pair in some bit position. It then steps the top partial-product bits and the multiplier bits through all four combinations. Chains of M/2 steps are fed back through the ports and compared with a bit-serial product. This exercises the pairing of multiplier bits from the most significant end.

// File: rtl/gfr4_pkg.sv
package gfr4_pkg;

  // Selection key built from a coefficient pair: bit 0 = lower-term key,
  // bit 1 = upper-term key.
  typedef enum logic [1:0] {
    PICK_NONE = 2'b00,
    PICK_LO   = 2'b01,
    PICK_HI   = 2'b10,
    PICK_BOTH = 2'b11
  } pick_e;

  function automatic pick_e pick_code(input logic lo_key, input logic hi_key);
    return pick_e'({hi_key, lo_key});
  endfunction

  // Candidate vector indexed by pick_e: {lo^hi, hi, lo, 0}
  function automatic logic [3:0] cand_set(input logic lo, input logic hi);
    return {lo ^ hi, hi, lo, 1'b0};
  endfunction

  function automatic logic xor3(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

endpackage

// File: rtl/gfr4_cand.sv
module gfr4_cand
  import gfr4_pkg::*;
(
  input  logic       x_lo,
  input  logic       x_hi,
  output logic [3:0] cand
);
  // One shared XOR per step feeds every bit position.
  always_comb cand = cand_set(x_lo, x_hi);
endmodule

// File: rtl/gfr4_mux4.sv
module gfr4_mux4
  import gfr4_pkg::*;
(
  input  logic [3:0] cand,
  input  pick_e      pick,
  output logic       y
);
  always_comb begin
    unique case (pick)
      PICK_NONE: y = cand[0];
      PICK_LO:   y = cand[1];
      PICK_HI:   y = cand[2];
      PICK_BOTH: y = cand[3];
      default:   y = 1'b0;
    endcase
  end
endmodule

// File: rtl/gfr4_cell.sv
module gfr4_cell
  import gfr4_pkg::*;
(
  input  logic [3:0] red_cand,
  input  logic [3:0] opd_cand,
  input  logic       p_lo_key,
  input  logic       p_hi_key,
  input  logic       a_lo_key,
  input  logic       a_hi_key,
  input  logic       shift_in,
  output logic       v_bit,
  output logic       k_bit,
  output logic       t_bit
);
  pick_e red_pick, opd_pick;

  always_comb begin
    red_pick = pick_code(p_lo_key, p_hi_key);
    opd_pick = pick_code(a_lo_key, a_hi_key);
  end

  gfr4_mux4 u_red (.cand(red_cand), .pick(red_pick), .y(v_bit));
  gfr4_mux4 u_opd (.cand(opd_cand), .pick(opd_pick), .y(k_bit));

  always_comb t_bit = xor3(shift_in, v_bit, k_bit);
endmodule

// File: rtl/gfr4_step.sv
module gfr4_step #(
  parameter int M = 8
) (
  input  logic [M-1:0] t_prev,
  input  logic [M-1:0] a_op,
  input  logic [M-1:0] a_shift,
  input  logic [M-1:0] poly,
  input  logic [M-1:0] poly_up,
  input  logic         b_hi,
  input  logic         b_lo,
  output logic [M-1:0] t_next
);
  localparam int TOP = M - 1;
  localparam int SUB = M - 2;

  // Named internal events for the checker
  logic [3:0]   red_cand;   // from the two top partial-product bits
  logic [3:0]   opd_cand;   // from the multiplier bit pair
  logic [M-1:0] v_bits;     // per-bit reduction terms
  logic [M-1:0] k_bits;     // per-bit operand terms
  logic [M-1:0] shift_bits; // partial product moved up by two places

  gfr4_cand u_red_cand (.x_lo(t_prev[SUB]), .x_hi(t_prev[TOP]), .cand(red_cand));
  gfr4_cand u_opd_cand (.x_lo(b_lo),        .x_hi(b_hi),        .cand(opd_cand));

  for (genvar j = 0; j < M; j++) begin : g_bit
    if (j >= 2) begin : g_shift
      assign shift_bits[j] = t_prev[j-2];
    end else begin : g_base
      assign shift_bits[j] = 1'b0;
    end

    gfr4_cell u_cell (
      .red_cand (red_cand),
      .opd_cand (opd_cand),
      .p_lo_key (poly[j]),
      .p_hi_key (poly_up[j]),
      .a_lo_key (a_op[j]),
      .a_hi_key (a_shift[j]),
      .shift_in (shift_bits[j]),
      .v_bit    (v_bits[j]),
      .k_bit    (k_bits[j]),
      .t_bit    (t_next[j])
    );
  end
endmodule

// File: rtl/gfr4_step_chk.sv
module gfr4_step_chk #(
  parameter int M = 8
) (
  input logic [M-1:0] t_prev,
  input logic [M-1:0] a_op,
  input logic [M-1:0] a_shift,
  input logic [M-1:0] poly,
  input logic [M-1:0] poly_up,
  input logic         b_hi,
  input logic         b_lo,
  input logic [M-1:0] t_next,
  input logic [M-1:0] v_bits,
  input logic [M-1:0] k_bits
);
  logic [M-1:0] moved;
  always_comb moved = {t_prev[M-3:0], 2'b00};

  always_comb begin
    assert_v_pick_R3: assert (v_bits ==
      ((poly & {M{t_prev[M-2]}}) ^ (poly_up & {M{t_prev[M-1]}})))
      else $error("R3 reduction selection mismatch");

    assert_k_pick_R4: assert (k_bits ==
      ((a_op & {M{b_lo}}) ^ (a_shift & {M{b_hi}})))
      else $error("R4 operand selection mismatch");

    assert_low_bits_R2: assert (!(!b_hi && !b_lo && t_prev[M-1:M-2] == 2'b00)
                                || t_next[1:0] == 2'b00)
      else $error("R2 low bits took a shifted term");

    assert_shift_only_R5: assert (b_hi || b_lo || t_next == (moved ^ v_bits))
      else $error("R5 operand leaked with zero multiplier bits");

    assert_no_reduce_R6: assert (t_prev[M-1:M-2] != 2'b00
                                 || t_next == (moved ^ k_bits))
      else $error("R6 reduction applied with clear top bits");
  end
endmodule

bind gfr4_step gfr4_step_chk #(.M(M)) u_chk (
  .t_prev(t_prev), .a_op(a_op), .a_shift(a_shift), .poly(poly),
  .poly_up(poly_up), .b_hi(b_hi), .b_lo(b_lo), .t_next(t_next),
  .v_bits(v_bits), .k_bits(k_bits)
);

// File: tb/sim_gfr4_step.sv
module sim_gfr4_step;
  localparam int M = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic [M-1:0] t_prev, a_op, a_shift, poly, poly_up, t_next;
  logic         b_hi, b_lo;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  gfr4_step #(.M(M)) u0 (
    .t_prev(t_prev), .a_op(a_op), .a_shift(a_shift), .poly(poly),
    .poly_up(poly_up), .b_hi(b_hi), .b_lo(b_lo), .t_next(t_next)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---- reference arithmetic ----
  function automatic logic [M-1:0] times_x(input logic [M-1:0] v, input logic [M-1:0] p);
    return {v[M-2:0], 1'b0} ^ (v[M-1] ? p : '0);
  endfunction

  function automatic logic [M-1:0] ref_step(input logic [M-1:0] t, input logic [M-1:0] a,
                                            input logic bh, input logic bl,
                                            input logic [M-1:0] p);
    logic [M-1:0] r;
    r = times_x(times_x(t, p), p);
    if (bh) r = r ^ times_x(a, p);
    if (bl) r = r ^ a;
    return r;
  endfunction

  function automatic logic [M-1:0] serial_mul(input logic [M-1:0] a, input logic [M-1:0] b,
                                              input logic [M-1:0] p);
    logic [M-1:0] r;
    r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      r = times_x(r, p);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [M-1:0] pick_poly(input int idx);
    case (idx % 4)
      0: return 8'h1B;
      1: return 8'h1D;
      2: return 8'h2B;
      default: return 8'h4D;
    endcase
  endfunction

  task automatic check(input string req, input logic [M-1:0] got, input logic [M-1:0] exp);
    n_cmp = n_cmp + 1;
    if (got !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive_raw(input logic [M-1:0] t, input logic [M-1:0] a,
                           input logic [M-1:0] as, input logic [M-1:0] p,
                           input logic [M-1:0] pu, input logic bh, input logic bl);
    @(posedge clk);
    t_prev = t; a_op = a; a_shift = as; poly = p; poly_up = pu;
    b_hi = bh; b_lo = bl;
    @(negedge clk);
  endtask

  task automatic drive(input logic [M-1:0] t, input logic [M-1:0] a,
                       input logic bh, input logic bl, input logic [M-1:0] p);
    drive_raw(t, a, times_x(a, p), p, times_x(p, p), bh, bl);
  endtask

  initial begin
    logic [M-1:0] t, a, b, p, r1, r2;
    void'($urandom(32'h5EED_0042));
    t_prev = '0; a_op = '0; a_shift = '0; poly = '0; poly_up = '0;
    b_hi = 1'b0; b_lo = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset/idle zero", t_next, '0);

    // R3: every key pair against every top-bit combination
    for (int c = 0; c < 4; c++) begin
      logic [M-1:0] pk, pu, exp;
      pk = 8'b1010_0110; pu = 8'b1100_1010;
      drive_raw({c[1], c[0], 6'b0}, '0, '0, pk, pu, 1'b0, 1'b0);
      exp = (pk & {M{c[0]}}) ^ (pu & {M{c[1]}});
      check("R3 reduction select", t_next, exp);
    end

    // R4: every key pair against every multiplier pair
    for (int c = 0; c < 4; c++) begin
      logic [M-1:0] ak, as, exp;
      ak = 8'b0101_1001; as = 8'b0011_0101;
      drive_raw('0, ak, as, 8'h1B, 8'h36, c[1], c[0]);
      exp = (ak & {M{c[0]}}) ^ (as & {M{c[1]}});
      check("R4 operand select", t_next, exp);
    end

    // R2: low bits with only shifted content
    drive_raw(8'h3F, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0);
    check("R2 low bits clear", {6'b0, t_next[1:0]}, '0);
    check("R2 shift only", t_next, 8'hFC);

    // R5: zero multiplier bits, A must not matter
    for (int n = 0; n < 6; n++) begin
      t = 8'($urandom); a = 8'($urandom); p = pick_poly(n);
      drive(t, a, 1'b0, 1'b0, p);
      check("R5 A ignored", t_next, times_x(times_x(t, p), p));
    end

    // R6: clear top bits, polynomial must not matter
    for (int n = 0; n < 6; n++) begin
      logic bh, bl;
      t = 8'($urandom) & 8'h3F; a = 8'($urandom);
      bh = 1'($urandom); bl = 1'($urandom);
      drive_raw(t, a, 8'h5A, 8'($urandom), 8'($urandom), bh, bl);
      check("R6 poly ignored", t_next,
            {t[M-3:0], 2'b00} ^ (bh ? 8'h5A : '0) ^ (bl ? a : '0));
    end

    // R7: same data, different fields
    t = 8'hC7; a = 8'h9E;
    drive(t, a, 1'b1, 1'b1, 8'h1B); r1 = t_next;
    check("R7 field 1B", r1, ref_step(t, a, 1'b1, 1'b1, 8'h1B));
    drive(t, a, 1'b1, 1'b1, 8'h1D); r2 = t_next;
    check("R7 field 1D", r2, ref_step(t, a, 1'b1, 1'b1, 8'h1D));

    // R1: random steps over several polynomials
    for (int n = 0; n < 300; n++) begin
      logic bh, bl;
      t = 8'($urandom); a = 8'($urandom); p = pick_poly(int'($urandom % 4));
      bh = 1'($urandom); bl = 1'($urandom);
      drive(t, a, bh, bl, p);
      check("R1 random step", t_next, ref_step(t, a, bh, bl, p));
    end

    // R8: full products chained through the port
    for (int n = 0; n < 40; n++) begin
      logic [M-1:0] acc;
      case (n)
        0: begin a = 8'hFF; b = 8'hFF; end
        1: begin a = 8'h01; b = 8'h80; end
        2: begin a = 8'h80; b = 8'h03; end
        default: begin a = 8'($urandom); b = 8'($urandom); end
      endcase
      p = pick_poly(n);
      acc = '0;
      for (int i = 1; i <= M / 2; i++) begin
        drive(acc, a, b[M - 2*i + 1], b[M - 2*i], p);
        acc = t_next;
      end
      check("R8 chained product", acc, serial_mul(a, b, p));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule